// File: doc/BRIEF.md
# External Data Address Steering Unit

This unit sits between a small 8-bit CPU and its data memories. For every external-data-move request it makes two decisions. It picks the target, which is either the on-chip XRAM or the off-chip memory bus. It also builds the full 16-bit address that goes with the request.

A request gives either a full 16-bit address or only a low byte. For a low-byte access, the upper byte comes from a page register or from the high byte of the port latches. Which one is used depends on the routing mode and on where the address falls.

Two control registers sit behind a simple write/read port:
- **Page register.** Holds the upper address byte for low-byte accesses.
- **Configuration register.** Holds the routing mode in bits 3–2. It also stores a port-select bit (bit 5), a multiplex-select bit (bit 4) and a two-bit ALE width (bits 1–0). Those three fields are stored and read back but do not affect routing.

The four routing modes are:
- keep everything on-chip, folding addresses into the on-chip size;
- split at the on-chip boundary, with port-latch upper byte for off-chip low-byte accesses;
- split at the on-chip boundary, with page-register upper byte;
- send everything off-chip.

Each request produces a registered, one-cycle select on exactly one target, together with the resolved address and the direction.

Top module: `xds_steer`

## Requirements
- R1: After reset, the page register reads 0x00 and the configuration register reads 0x03, which is the on-chip-only routing mode. Neither select is asserted.
- R2: The configuration register reads bits 7–6 as 0, and writes to those bits are ignored. Bits 5–0 read back as written. Register select 0 addresses the page register and select 1 addresses the configuration register.
- R3: For a low-byte access, the upper address byte is the page register. The only exception is R5's off-chip case. Bits 15–8 of the address input are ignored for such an access.
- R4: Mode field value 00 (configuration bits 3–2) routes every request on-chip. The address is masked to the on-chip size, ONCHIP_BYTES, which defaults to 4096.
- R5: Mode 01 routes an address below ONCHIP_BYTES on-chip and any other address off-chip. The page-built address is what decides. A low-byte access routed off-chip takes its upper byte from the port-latch high byte.
- R6: Mode 10 uses the same split as mode 01. Every low-byte access in this mode takes its upper byte from the page register.
- R7: Mode 11 routes every request off-chip and never asserts the on-chip select. The address is passed through unmasked.
- R8: A 16-bit access in modes 01, 10 and 11 presents its address unchanged. The page register and port latches are ignored.
- R9: A request sampled at a clock edge asserts exactly one of the two selects for the single following cycle. A cycle without a request asserts neither select.
- R10: A register write in the same cycle as a request does not affect that request. It takes effect from the next request onward.
- R11: The direction output repeats the read/write flag of the request alongside its select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 page, 1 configuration |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data of the selected register |
| req_i | input | 1 | Data move request strobe |
| wr_i | input | 1 | Request direction: 1 write, 0 read |
| wide_i | input | 1 | 1: 16-bit address access, 0: low-byte access |
| addr_i | input | 16 | Request address (low byte only when wide_i is 0) |
| port_hi_i | input | 8 | Port-latch high byte |
| onchip_sel_o | output | 1 | On-chip XRAM select, one cycle per request |
| offchip_sel_o | output | 1 | Off-chip bus select, one cycle per request |
| addr_o | output | 16 | Resolved 16-bit address |
| wr_o | output | 1 | Direction of the selected request |

## Verification
The bench builds the unit with its default parameters: an 8-bit register width and a 4096-byte on-chip size. With these values the split boundary falls between page 0x0F and page 0x10. A low-byte access can therefore land on either side of the boundary just by moving the page register. The 16-bit vectors at 0x0FFF and 0x1000 test the same edge directly. The 4 kB mask is small enough that a single vector can show aliasing from a high page.

// File: rtl/xds_pkg.sv
package xds_pkg;
  typedef enum logic [1:0] {
    RT_LOCAL      = 2'b00,
    RT_SPLIT_PORT = 2'b01,
    RT_SPLIT_PAGE = 2'b10,
    RT_REMOTE     = 2'b11
  } route_mode_e;

  localparam int CFG_MODE_LSB = 2;
  localparam int CFG_KEEP_W   = 6;
endpackage

// File: rtl/xds_regs.sv
module xds_regs import xds_pkg::*; #(
  parameter int RW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_wr_i,
  input  logic          reg_sel_i,
  input  logic [RW-1:0] reg_wdata_i,
  output logic [RW-1:0] reg_rdata_o,
  output logic [RW-1:0] page_o,
  output route_mode_e   mode_o
);
  localparam int PADW = RW - CFG_KEEP_W;

  logic [RW-1:0]         page_q;
  logic [CFG_KEEP_W-1:0] cfg_q;
  logic [RW-1:0]         cfg_view;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
      cfg_q  <= CFG_KEEP_W'(3);
    end else if (reg_wr_i) begin
      if (reg_sel_i) cfg_q  <= reg_wdata_i[CFG_KEEP_W-1:0];
      else           page_q <= reg_wdata_i;
    end
  end

  assign cfg_view    = {{PADW{1'b0}}, cfg_q};
  assign reg_rdata_o = reg_sel_i ? cfg_view : page_q;
  assign page_o      = page_q;
  assign mode_o      = route_mode_e'(cfg_q[CFG_MODE_LSB +: 2]);

  // R2: readback masks the unimplemented top bits
  a_r2_cfg_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_sel_i) |=>
      (cfg_view == ($past(reg_wdata_i) & {{PADW{1'b0}}, {CFG_KEEP_W{1'b1}}})));
  // R2: page write lands unchanged
  a_r2_page_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && !reg_sel_i) |=> (page_o == $past(reg_wdata_i)));
endmodule

// File: rtl/xds_route.sv
module xds_route import xds_pkg::*; #(
  parameter int RW           = 8,
  parameter int ONCHIP_BYTES = 4096
) (
  input  route_mode_e      mode_i,
  input  logic             wide_i,
  input  logic [2*RW-1:0]  addr_i,
  input  logic [RW-1:0]    page_i,
  input  logic [RW-1:0]    port_hi_i,
  output logic             local_o,
  output logic [2*RW-1:0]  addr_o
);
  localparam int AW = 2 * RW;
  localparam logic [AW-1:0] LIMIT = AW'(ONCHIP_BYTES);
  localparam logic [AW-1:0] MASK  = AW'(ONCHIP_BYTES - 1);

  logic [AW-1:0] page_addr;
  logic [AW-1:0] port_addr;
  logic          below;

  assign page_addr = wide_i ? addr_i : {page_i, addr_i[RW-1:0]};
  assign port_addr = {port_hi_i, addr_i[RW-1:0]};
  assign below     = page_addr < LIMIT;

  always_comb begin
    local_o = 1'b0;
    addr_o  = page_addr;
    unique case (mode_i)
      RT_LOCAL: begin
        local_o = 1'b1;
        addr_o  = page_addr & MASK;
      end
      RT_SPLIT_PORT: begin
        local_o = below;
        if (!below && !wide_i) addr_o = port_addr;
      end
      RT_SPLIT_PAGE: local_o = below;
      RT_REMOTE:     local_o = 1'b0;
      default:       local_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/xds_issue.sv
module xds_issue #(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          wr_i,
  input  logic          local_i,
  input  logic [AW-1:0] addr_i,
  output logic          onchip_sel_o,
  output logic          offchip_sel_o,
  output logic [AW-1:0] addr_o,
  output logic          wr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      onchip_sel_o  <= 1'b0;
      offchip_sel_o <= 1'b0;
      addr_o        <= '0;
      wr_o          <= 1'b0;
    end else begin
      onchip_sel_o  <= req_i & local_i;
      offchip_sel_o <= req_i & ~local_i;
      if (req_i) begin
        addr_o <= addr_i;
        wr_o   <= wr_i;
      end
    end
  end

  // R11: direction travels with the select
  a_r11_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (wr_o == $past(wr_i)));
endmodule

// File: rtl/xds_steer.sv
module xds_steer import xds_pkg::*; #(
  parameter int RW           = 8,
  parameter int ONCHIP_BYTES = 4096
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_wr_i,
  input  logic            reg_sel_i,
  input  logic [RW-1:0]   reg_wdata_i,
  output logic [RW-1:0]   reg_rdata_o,
  input  logic            req_i,
  input  logic            wr_i,
  input  logic            wide_i,
  input  logic [2*RW-1:0] addr_i,
  input  logic [RW-1:0]   port_hi_i,
  output logic            onchip_sel_o,
  output logic            offchip_sel_o,
  output logic [2*RW-1:0] addr_o,
  output logic            wr_o
);
  localparam int AW = 2 * RW;

  logic [RW-1:0] page;
  route_mode_e   mode;
  logic          route_local;
  logic [AW-1:0] route_addr;

  xds_regs #(.RW(RW)) i_regs (
    .clk_i, .rst_ni, .reg_wr_i, .reg_sel_i, .reg_wdata_i, .reg_rdata_o,
    .page_o(page), .mode_o(mode)
  );

  xds_route #(.RW(RW), .ONCHIP_BYTES(ONCHIP_BYTES)) i_route (
    .mode_i(mode), .wide_i, .addr_i, .page_i(page), .port_hi_i,
    .local_o(route_local), .addr_o(route_addr)
  );

  xds_issue #(.AW(AW)) i_issue (
    .clk_i, .rst_ni, .req_i, .wr_i, .local_i(route_local), .addr_i(route_addr),
    .onchip_sel_o, .offchip_sel_o, .addr_o, .wr_o
  );

  // R9
  a_r9_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({onchip_sel_o, offchip_sel_o}));
  a_r9_one_per_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (onchip_sel_o || offchip_sel_o));
  a_r9_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !(onchip_sel_o || offchip_sel_o));
  // R4
  a_r4_local_alias: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && mode == RT_LOCAL) |=> (onchip_sel_o && addr_o < AW'(ONCHIP_BYTES)));
  // R7
  a_r7_remote: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && mode == RT_REMOTE) |=> offchip_sel_o);
  // R5 / R6: wide access above the boundary leaves the chip
  a_r5_split_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && wide_i && (mode == RT_SPLIT_PORT || mode == RT_SPLIT_PAGE)
     && addr_i >= AW'(ONCHIP_BYTES)) |=> offchip_sel_o);
  // R8
  a_r8_wide_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && wide_i && mode != RT_LOCAL) |=> (addr_o == $past(addr_i)));
endmodule

// File: tb/test_xds_steer.sv
module test_xds_steer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr_i = 1'b0, reg_sel_i = 1'b0;
  logic [7:0]  reg_wdata_i = '0, reg_rdata_o;
  logic        req_i = 1'b0, wr_i = 1'b0, wide_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic [7:0]  port_hi_i = '0;
  logic        onchip_sel_o, offchip_sel_o, wr_o;
  logic [15:0] addr_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  xds_steer i_xds_steer (.*);

  typedef struct packed {
    logic [1:0]  mode;
    logic        wide;
    logic        wr;
    logic [15:0] addr;
    logic [7:0]  page;
    logic [7:0]  port;
    logic        exp_on;
    logic [15:0] exp_addr;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 1'b0, 1'b0, 16'hEE34, 8'h25, 8'h00, 1'b1, 16'h0534}, // R4 R3
    '{2'b00, 1'b1, 1'b1, 16'hABCD, 8'h00, 8'h00, 1'b1, 16'h0BCD}, // R4
    '{2'b01, 1'b0, 1'b0, 16'hEE10, 8'h0F, 8'h77, 1'b1, 16'h0F10}, // R5 below
    '{2'b01, 1'b0, 1'b1, 16'hEE10, 8'h10, 8'h77, 1'b0, 16'h7710}, // R5 port hi
    '{2'b01, 1'b1, 1'b0, 16'h1000, 8'h00, 8'h55, 1'b0, 16'h1000}, // R5 R8 edge
    '{2'b01, 1'b1, 1'b1, 16'h0FFF, 8'hF0, 8'h55, 1'b1, 16'h0FFF}, // R5 R8 edge
    '{2'b10, 1'b0, 1'b0, 16'hEEFF, 8'hFF, 8'h12, 1'b0, 16'hFFFF}, // R6
    '{2'b10, 1'b0, 1'b1, 16'hEE00, 8'h00, 8'h12, 1'b1, 16'h0000}, // R6
    '{2'b10, 1'b1, 1'b0, 16'h2345, 8'h99, 8'h12, 1'b0, 16'h2345}, // R6 R8
    '{2'b10, 1'b0, 1'b1, 16'hEE80, 8'h10, 8'h00, 1'b0, 16'h1080}, // R6 edge
    '{2'b11, 1'b0, 1'b0, 16'hEE01, 8'h00, 8'h33, 1'b0, 16'h0001}, // R7 R3
    '{2'b11, 1'b1, 1'b1, 16'h0800, 8'h44, 8'h33, 1'b0, 16'h0800}, // R7 R8
    '{2'b00, 1'b0, 1'b1, 16'hEEFF, 8'hFF, 8'h00, 1'b1, 16'h0FFF}  // R4 alias
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(logic sel, logic [7:0] d);
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  task automatic reg_read(logic sel, output logic [7:0] d);
    reg_sel_i = sel;
    #1 d = reg_rdata_o;
  endtask

  // drive at negedge, captured next posedge, sampled next negedge
  task automatic issue(logic wide, logic wr, logic [15:0] a, logic [7:0] ph);
    @(negedge clk_i);
    req_i = 1'b1; wide_i = wide; wr_i = wr; addr_i = a; port_hi_i = ph;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    reg_read(1'b0, rd); chk("R1 page reset", rd, 8'h00);
    reg_read(1'b1, rd); chk("R1 cfg reset", rd, 8'h03);
    chk("R1 selects idle", {onchip_sel_o, offchip_sel_o}, 2'b00);

    // R2 upper bits ignored
    reg_write(1'b1, 8'hFF);
    reg_read(1'b1, rd); chk("R2 cfg mask", rd, 8'h3F);
    reg_write(1'b1, 8'hA5);
    reg_read(1'b1, rd); chk("R2 cfg mask2", rd, 8'h25);

    foreach (VECS[i]) begin
      vec_t v = VECS[i];
      reg_write(1'b1, {4'b0, v.mode, 2'b11});
      reg_write(1'b0, v.page);
      issue(v.wide, v.wr, v.addr, v.port);
      chk($sformatf("R9 vec%0d sel", i), {onchip_sel_o, offchip_sel_o}, {v.exp_on, ~v.exp_on});
      chk($sformatf("R3 vec%0d addr", i), addr_o, v.exp_addr);
      chk($sformatf("R11 vec%0d dir", i), wr_o, v.wr);
      @(negedge clk_i);
      chk($sformatf("R9 vec%0d single", i), {onchip_sel_o, offchip_sel_o}, 2'b00);
    end

    // R10 write concurrent with request uses old mode
    reg_write(1'b1, 8'h00);
    reg_write(1'b0, 8'h20);
    @(negedge clk_i);
    req_i = 1'b1; wide_i = 1'b1; wr_i = 1'b0; addr_i = 16'h3456;
    reg_wr_i = 1'b1; reg_sel_i = 1'b1; reg_wdata_i = 8'h0C;
    @(negedge clk_i);
    req_i = 1'b0; reg_wr_i = 1'b0;
    chk("R10 old mode on", {onchip_sel_o, offchip_sel_o}, 2'b10);
    chk("R10 old mode addr", addr_o, 16'h0456);
    issue(1'b1, 1'b0, 16'h3456, 8'h00);
    chk("R10 new mode off", {onchip_sel_o, offchip_sel_o}, 2'b01);
    chk("R10 new mode addr", addr_o, 16'h3456);

    // R9 back-to-back requests, each one cycle
    @(negedge clk_i);
    req_i = 1'b1; wide_i = 1'b1; addr_i = 16'h0100; wr_i = 1'b1;
    @(negedge clk_i);
    chk("R9 b2b first", offchip_sel_o, 1'b1);
    addr_i = 16'h0200; wr_i = 1'b0;
    @(negedge clk_i);
    req_i = 1'b0;
    chk("R9 b2b second addr", addr_o, 16'h0200);
    chk("R11 b2b dir", wr_o, 1'b0);
    @(negedge clk_i);
    chk("R9 idle after", {onchip_sel_o, offchip_sel_o}, 2'b00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule